// File: doc/BRIEF.md
# In-Flight Instruction Active List

This block keeps the program order of every instruction that an out-of-order core has dispatched but not yet retired. It is a circular list of 48 entries. Each entry holds the new physical destination register that the instruction writes, the physical register that the same architectural register mapped to before, and a one-bit state: active while the instruction executes, done once its result exists. Dispatch claims up to four consecutive entries per cycle at the tail. Execution units report completion by naming an entry tag.

Every cycle, the block offers for retirement the longest run of done entries that starts at the oldest entry, up to four of them. Each retiring lane gives out the stale physical register, which goes back to the free pool, and the destination register, which lets the architectural map be committed. A mispredict flush names a tag. It drops that entry and everything younger, so that a correct path can be dispatched from that point. Tags are seven bits wide: bit 6 is a wrap flag that toggles each time a pointer passes slot 47, and bits 5:0 are the slot index. With 64 physical registers, register numbers are six bits.

Top module: `inflight_list`

## Requirements
- R1: `occupancy` reports the number of live entries, from 0 to 48. `full` is high exactly when 48 entries are live, and `empty` is high exactly when none are.
- R2: An accepted dispatch of `disp_num` (1 to 4) writes lane i of `disp_pdst`/`disp_pold` (bits 6i+5:6i) into the i-th consecutive entry from the tail, in the active state. `disp_tag` shows the tail tag, which is the tag the lane-0 instruction receives.
- R3: `disp_stall` is high when `disp_num` is above 4 or above the number of free entries. A stalled or flushed request allocates nothing and leaves `disp_tag` unchanged.
- R4: A completion port with a valid tag that lies inside the live list marks that entry done on the next edge. A tag outside the live list, or inside the part being flushed in the same cycle, is ignored.
- R5: Retirement is in program order. Lane j (bits 6j+5:6j of `ret_pdst`/`ret_pold`) is valid only if all older lanes are valid and the j-th oldest entry is done. The run therefore stops at the first active entry, and it is at most 4 long. The valid entries leave the list at that edge.
- R6: A flush with tag T discards T and all younger entries. The tail becomes T. A dispatch in the same cycle is discarded, and only entries older than T may retire in that cycle.
- R7: Head and tail advance modulo 48. The tag wrap bit toggles on each pass, so a full list and an empty list are told apart and tags stay ordered across the wrap.
- R8: After reset the list is empty, `disp_tag` is 0 and no retire lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_num | input | 3 | Number of instructions offered for dispatch this cycle |
| disp_pdst | input | 24 | New physical destination per dispatch lane |
| disp_pold | input | 24 | Previous mapping per dispatch lane |
| cmpl_vld | input | 2 | Completion port valid flags |
| cmpl_tag | input | 14 | Entry tag per completion port (7 bits each) |
| flush_vld | input | 1 | Mispredict flush request |
| flush_tag | input | 7 | Oldest entry to discard |
| disp_stall | output | 1 | Dispatch request cannot be accepted |
| disp_tag | output | 7 | Tag given to dispatch lane 0 |
| ret_vld | output | 4 | Retire lane valid, contiguous from lane 0 |
| ret_pdst | output | 24 | Destination register of each retiring entry |
| ret_pold | output | 24 | Register returned to the free pool per lane |
| occupancy | output | 6 | Live entry count |
| full | output | 1 | 48 entries live |
| empty | output | 1 | No entry live |

## Verification
The retire lanes, `occupancy`, `full`, `empty`, `disp_tag` and `disp_stall` are combinational views of the pointer and entry registers. `disp_stall` and the retire lanes also depend on the current flush and dispatch inputs. Dispatch, completion, flush and retirement take effect on the next rising edge, so a completion first shows up as a retire lane one cycle after it is presented. The bench drives inputs just after a falling edge and compares every output one nanosecond later. It then steps a queue-based model by exactly one edge, so model and design always advance together.

// File: rtl/il_pkg.sv
// Shared definitions for the in-flight active list.
// Assumes: ring positions are non-negative and below the span passed in.
package il_pkg;

    typedef enum logic {
        ST_ACTIVE = 1'b0,
        ST_DONE   = 1'b1
    } il_state_e;

    // Advance a ring position by n, wrapping once at span (n <= span).
    function automatic int unsigned ring_add(int unsigned pos, int unsigned n, int unsigned span);
        int unsigned s;
        s = pos + n;
        return (s >= span) ? s - span : s;
    endfunction

    // Forward distance from b to a on a ring of the given span.
    function automatic int unsigned ring_dist(int unsigned a, int unsigned b, int unsigned span);
        return (a >= b) ? a - b : a + span - b;
    endfunction

endpackage

// File: rtl/il_ring_ptr.sv
// Ring pointer held as a linear position in [0, 2*DEPTH): the upper half
// stands for the wrap bit being set. Advances by a step or loads a value.
// Assumes: step <= DEPTH and load_pos < 2*DEPTH.
module il_ring_ptr #(
    parameter int DEPTH  = 48,
    parameter int STEP_W = 3,
    localparam int TAG_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TAG_W-1:0]  load_pos,
    input  logic [STEP_W-1:0] step,
    output logic [TAG_W-1:0]  pos_q
);

    logic [TAG_W-1:0] pos_d;

    // Next position: a load wins over an advance.
    always_comb begin
        if (load) pos_d = load_pos;
        else      pos_d = TAG_W'(il_pkg::ring_add(32'(pos_q), 32'(step), 2 * DEPTH));
    end

    // Pointer register with synchronous reset to position zero.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

endmodule

// File: rtl/il_entry_array.sv
// Entry storage: per slot, the new destination, the old mapping and the
// active/done state. Allocation writes all three; completion sets done.
// Assumes: no slot is allocated and completed in the same cycle.
module il_entry_array #(
    parameter int DEPTH  = 48,
    parameter int LANES  = 4,
    parameter int CPORTS = 2,
    parameter int PREG_W = 6,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_we  [LANES],
    input  logic [IDX_W-1:0]  alloc_idx [LANES],
    input  logic [PREG_W-1:0] alloc_pdst[LANES],
    input  logic [PREG_W-1:0] alloc_pold[LANES],
    input  logic              cmpl_we   [CPORTS],
    input  logic [IDX_W-1:0]  cmpl_idx  [CPORTS],
    output logic [DEPTH-1:0]  done_vec,
    output logic [PREG_W-1:0] pdst_q    [DEPTH],
    output logic [PREG_W-1:0] pold_q    [DEPTH]
);

    import il_pkg::*;

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        il_state_e state_q;

        // Per-slot update: completion marks done, allocation overrides.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q   <= ST_ACTIVE;
                pdst_q[e] <= '0;
                pold_q[e] <= '0;
            end else begin
                for (int c = 0; c < CPORTS; c++) begin
                    if (cmpl_we[c] && cmpl_idx[c] == IDX_W'(e)) state_q <= ST_DONE;
                end
                for (int l = 0; l < LANES; l++) begin
                    if (alloc_we[l] && alloc_idx[l] == IDX_W'(e)) begin
                        state_q   <= ST_ACTIVE;
                        pdst_q[e] <= alloc_pdst[l];
                        pold_q[e] <= alloc_pold[l];
                    end
                end
            end
        end

        assign done_vec[e] = (state_q == ST_DONE);
    end

endmodule

// File: rtl/il_retire_pick.sv
// Retire selection: scans the LANES oldest slots from the head and keeps
// the leading run of done entries that lie below the given limit.
// Assumes: limit <= live count; slots past the limit are ignored.
module il_retire_pick #(
    parameter int DEPTH  = 48,
    parameter int LANES  = 4,
    parameter int PREG_W = 6,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int TAG_W  = IDX_W + 1,
    localparam int LCNT_W = $clog2(LANES + 1)
) (
    input  logic [IDX_W-1:0]      head_idx,
    input  logic [TAG_W-1:0]      limit,
    input  logic [DEPTH-1:0]      done_vec,
    input  logic [PREG_W-1:0]     pdst_q [DEPTH],
    input  logic [PREG_W-1:0]     pold_q [DEPTH],
    output logic [LANES-1:0]      ret_vld,
    output logic [LANES*PREG_W-1:0] ret_pdst,
    output logic [LANES*PREG_W-1:0] ret_pold,
    output logic [LCNT_W-1:0]     ret_num
);

    logic [IDX_W-1:0] slot [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign slot[j] = IDX_W'(il_pkg::ring_add(32'(head_idx), 32'(j), DEPTH));
        assign ret_pdst[j*PREG_W +: PREG_W] = pdst_q[slot[j]];
        assign ret_pold[j*PREG_W +: PREG_W] = pold_q[slot[j]];
    end

    // In-order run: a lane is valid only while every older lane was valid.
    always_comb begin
        logic run;
        run     = 1'b1;
        ret_num = '0;
        for (int j = 0; j < LANES; j++) begin
            run        = run && (32'(j) < 32'(limit)) && done_vec[slot[j]];
            ret_vld[j] = run;
            if (run) ret_num = ret_num + 1'b1;
        end
    end

endmodule

// File: rtl/inflight_list.sv
// In-flight active list top: circular program-order list of dispatched
// instructions with multi-lane dispatch, tag completion, in-order
// retirement and tag-based flush. Tags are {wrap, slot index}.
// Assumes: a flush tag lies in the live list or equals the tail tag.
module inflight_list #(
    parameter int DEPTH     = 48,
    parameter int LANES     = 4,
    parameter int CPORTS    = 2,
    parameter int NUM_PREGS = 64,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int TAG_W  = IDX_W + 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LCNT_W = $clog2(LANES + 1),
    localparam int PREG_W = $clog2(NUM_PREGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LCNT_W-1:0]        disp_num,
    input  logic [LANES*PREG_W-1:0]  disp_pdst,
    input  logic [LANES*PREG_W-1:0]  disp_pold,
    input  logic [CPORTS-1:0]        cmpl_vld,
    input  logic [CPORTS*TAG_W-1:0]  cmpl_tag,
    input  logic                     flush_vld,
    input  logic [TAG_W-1:0]         flush_tag,
    output logic                     disp_stall,
    output logic [TAG_W-1:0]         disp_tag,
    output logic [LANES-1:0]         ret_vld,
    output logic [LANES*PREG_W-1:0]  ret_pdst,
    output logic [LANES*PREG_W-1:0]  ret_pold,
    output logic [CNT_W-1:0]         occupancy,
    output logic                     full,
    output logic                     empty
);

    localparam int SPAN = 2 * DEPTH;

    // Tag {wrap, idx} to linear ring position.
    function automatic logic [TAG_W-1:0] tag2pos(logic [TAG_W-1:0] t);
        return t[TAG_W-1] ? TAG_W'(t[IDX_W-1:0]) + TAG_W'(DEPTH) : TAG_W'(t[IDX_W-1:0]);
    endfunction

    // Linear ring position to tag {wrap, idx}.
    function automatic logic [TAG_W-1:0] pos2tag(logic [TAG_W-1:0] p);
        if (p >= TAG_W'(DEPTH)) return {1'b1, IDX_W'(p - TAG_W'(DEPTH))};
        else                    return {1'b0, p[IDX_W-1:0]};
    endfunction

    logic [TAG_W-1:0]  head_pos, tail_pos, flush_pos;
    logic [TAG_W-1:0]  live, flush_dist, ret_limit;
    logic [CNT_W-1:0]  free_cnt;
    logic              accept;
    logic [LCNT_W-1:0] acc_num, ret_num;
    logic [DEPTH-1:0]  done_vec;
    logic [PREG_W-1:0] pdst_q [DEPTH];
    logic [PREG_W-1:0] pold_q [DEPTH];
    logic              alloc_we  [LANES];
    logic [IDX_W-1:0]  alloc_idx [LANES];
    logic [PREG_W-1:0] alloc_pdst[LANES];
    logic [PREG_W-1:0] alloc_pold[LANES];
    logic              cmpl_we   [CPORTS];
    logic [IDX_W-1:0]  cmpl_idx  [CPORTS];

    // Occupancy, flush distance and the retire bound in the flush cycle.
    always_comb begin
        live       = TAG_W'(il_pkg::ring_dist(32'(tail_pos), 32'(head_pos), SPAN));
        flush_pos  = tag2pos(flush_tag);
        flush_dist = TAG_W'(il_pkg::ring_dist(32'(flush_pos), 32'(head_pos), SPAN));
        ret_limit  = (flush_vld && flush_dist < live) ? flush_dist : live;
        free_cnt   = CNT_W'(DEPTH) - CNT_W'(live);
    end

    // Dispatch acceptance: the whole group fits or nothing is taken.
    always_comb begin
        disp_stall = (32'(disp_num) > 32'(LANES)) || (32'(disp_num) > 32'(free_cnt));
        accept     = !flush_vld && !disp_stall;
        acc_num    = accept ? disp_num : '0;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_alloc
        assign alloc_we[l]   = accept && (32'(l) < 32'(disp_num));
        assign alloc_idx[l]  = pos2tag(TAG_W'(il_pkg::ring_add(32'(tail_pos), 32'(l), SPAN)))[IDX_W-1:0];
        assign alloc_pdst[l] = disp_pdst[l*PREG_W +: PREG_W];
        assign alloc_pold[l] = disp_pold[l*PREG_W +: PREG_W];
    end

    for (genvar c = 0; c < CPORTS; c++) begin : g_cmpl
        logic [TAG_W-1:0] c_tag, c_dist;
        assign c_tag  = cmpl_tag[c*TAG_W +: TAG_W];
        assign c_dist = TAG_W'(il_pkg::ring_dist(32'(tag2pos(c_tag)), 32'(head_pos), SPAN));
        // Only live, unflushed entries may be marked done.
        assign cmpl_we[c]  = cmpl_vld[c] && (c_dist < live) && !(flush_vld && c_dist >= flush_dist);
        assign cmpl_idx[c] = c_tag[IDX_W-1:0];
    end

    il_ring_ptr #(.DEPTH(DEPTH), .STEP_W(LCNT_W)) u_head (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_pos('0),
        .step(ret_num), .pos_q(head_pos)
    );

    il_ring_ptr #(.DEPTH(DEPTH), .STEP_W(LCNT_W)) u_tail (
        .clk(clk), .rst_n(rst_n), .load(flush_vld), .load_pos(flush_pos),
        .step(acc_num), .pos_q(tail_pos)
    );

    il_entry_array #(.DEPTH(DEPTH), .LANES(LANES), .CPORTS(CPORTS), .PREG_W(PREG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .alloc_we(alloc_we), .alloc_idx(alloc_idx),
        .alloc_pdst(alloc_pdst), .alloc_pold(alloc_pold),
        .cmpl_we(cmpl_we), .cmpl_idx(cmpl_idx),
        .done_vec(done_vec), .pdst_q(pdst_q), .pold_q(pold_q)
    );

    il_retire_pick #(.DEPTH(DEPTH), .LANES(LANES), .PREG_W(PREG_W)) u_pick (
        .head_idx(pos2tag(head_pos)[IDX_W-1:0]), .limit(ret_limit),
        .done_vec(done_vec), .pdst_q(pdst_q), .pold_q(pold_q),
        .ret_vld(ret_vld), .ret_pdst(ret_pdst), .ret_pold(ret_pold), .ret_num(ret_num)
    );

    assign disp_tag  = pos2tag(tail_pos);
    assign occupancy = CNT_W'(live);
    assign full      = (live == TAG_W'(DEPTH));
    assign empty     = (live == '0);

endmodule

// File: rtl/il_checker.sv
// Protocol checker for the in-flight active list, bound to the top.
module il_checker #(
    parameter int DEPTH = 48,
    parameter int LANES = 4,
    parameter int CPORTS = 2,
    parameter int NUM_PREGS = 64,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int TAG_W  = IDX_W + 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LCNT_W = $clog2(LANES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LCNT_W-1:0] disp_num,
    input logic              flush_vld,
    input logic [TAG_W-1:0]  flush_tag,
    input logic              disp_stall,
    input logic [TAG_W-1:0]  disp_tag,
    input logic [LANES-1:0]  ret_vld,
    input logic [CNT_W-1:0]  occupancy,
    input logic              empty
);

    a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occupancy) <= 32'(DEPTH));

    a_r8_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (empty && ret_vld == '0 && disp_tag == '0));

    a_r3_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_stall && !flush_vld) |=> (occupancy <= $past(occupancy)));

    a_r2_count_balance: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_vld |=> (int'(occupancy) == int'($past(occupancy))
            + ($past(disp_stall) ? 0 : int'($past(disp_num)))
            - int'($countones($past(ret_vld)))));

    a_r5_empty_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (ret_vld == '0));

    for (genvar j = 1; j < LANES; j++) begin : g_contig
        a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
            ret_vld[j] |-> ret_vld[j-1]);
    end

    a_r6_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld |=> (disp_tag == $past(flush_tag)));

endmodule

bind inflight_list il_checker #(
    .DEPTH(DEPTH), .LANES(LANES), .CPORTS(CPORTS), .NUM_PREGS(NUM_PREGS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_num(disp_num), .flush_vld(flush_vld),
    .flush_tag(flush_tag), .disp_stall(disp_stall), .disp_tag(disp_tag),
    .ret_vld(ret_vld), .occupancy(occupancy), .empty(empty)
);

// File: tb/inflight_list_tb.sv
`timescale 1ns/1ps
// Bench: queue-based reference model stepped once per clock and compared
// against every output of the active list.
module inflight_list_tb;

    localparam int D = 48;
    localparam int SPAN = 2 * D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  disp_num = '0;
    logic [23:0] disp_pdst = '0, disp_pold = '0;
    logic [1:0]  cmpl_vld = '0;
    logic [13:0] cmpl_tag = '0;
    logic        flush_vld = 1'b0;
    logic [6:0]  flush_tag = '0;
    logic        disp_stall, full, empty;
    logic [6:0]  disp_tag;
    logic [3:0]  ret_vld;
    logic [23:0] ret_pdst, ret_pold;
    logic [5:0]  occupancy;

    inflight_list u_dut (
        .clk(clk), .rst_n(rst_n), .disp_num(disp_num), .disp_pdst(disp_pdst),
        .disp_pold(disp_pold), .cmpl_vld(cmpl_vld), .cmpl_tag(cmpl_tag),
        .flush_vld(flush_vld), .flush_tag(flush_tag), .disp_stall(disp_stall),
        .disp_tag(disp_tag), .ret_vld(ret_vld), .ret_pdst(ret_pdst),
        .ret_pold(ret_pold), .occupancy(occupancy), .full(full), .empty(empty)
    );

    always #2.5 clk = ~clk;

    typedef struct { int pos; int pdst; int pold; bit done; } ent_t;
    ent_t q[$];
    int head_pos = 0, tail_pos = 0;
    int vectors = 0, fails = 0;
    string ph = "R8";

    int g_dn = 0, g_fv = 0, g_fpos = 0;
    int g_cv[2], g_cpos[2];

    function automatic logic [6:0] to_tag(int p);
        return (p >= D) ? {1'b1, 6'(p - D)} : {1'b0, 6'(p)};
    endfunction

    function automatic int fwd(int a, int b);
        return (a >= b) ? a - b : a + SPAN - b;
    endfunction

    task automatic chk(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", ph, what, act, exp);
        end
    endtask

    // One clock: drive, compare outputs, then advance the model one edge.
    task automatic step();
        int occ, lim, fd, k, pd[4], po[4];
        bit stall;
        @(negedge clk);
        for (int l = 0; l < 4; l++) begin
            pd[l] = int'($urandom_range(63));
            po[l] = int'($urandom_range(63));
            disp_pdst[l*6 +: 6] = 6'(pd[l]);
            disp_pold[l*6 +: 6] = 6'(po[l]);
        end
        disp_num = 3'(g_dn);
        for (int c = 0; c < 2; c++) begin
            cmpl_vld[c] = (g_cv[c] != 0);
            cmpl_tag[c*7 +: 7] = to_tag(g_cpos[c]);
        end
        flush_vld = (g_fv != 0);
        flush_tag = to_tag(g_fpos);
        #1;
        occ = q.size();
        stall = (g_dn > 4) || (g_dn > D - occ);
        fd = fwd(g_fpos, head_pos);
        lim = (g_fv != 0 && fd < occ) ? fd : occ;
        k = 0;
        while (k < 4 && k < lim && q[k].done) k++;
        chk("R1 occupancy", int'(occupancy), occ);
        chk("R1 full", int'(full), int'(occ == D));
        chk("R1 empty", int'(empty), int'(occ == 0));
        chk("R2 disp_tag", int'(disp_tag), int'(to_tag(tail_pos)));
        chk("R3 disp_stall", int'(disp_stall), int'(stall));
        chk("R5 ret_vld", int'(ret_vld), (1 << k) - 1);
        for (int j = 0; j < k; j++) begin
            chk("R5 ret_pold", int'(ret_pold[j*6 +: 6]), q[j].pold);
            chk("R5 ret_pdst", int'(ret_pdst[j*6 +: 6]), q[j].pdst);
        end
        // Model update: completion, flush, retirement, dispatch.
        for (int c = 0; c < 2; c++) begin
            int d;
            d = fwd(g_cpos[c], head_pos);
            if (g_cv[c] != 0 && d < occ && !(g_fv != 0 && d >= fd)) q[d].done = 1'b1;
        end
        if (g_fv != 0) begin
            while (q.size() > fd) void'(q.pop_back());
            tail_pos = g_fpos;
        end
        for (int j = 0; j < k; j++) void'(q.pop_front());
        head_pos = (head_pos + k) % SPAN;
        if (g_fv == 0 && !stall) begin
            for (int l = 0; l < g_dn; l++) begin
                q.push_back('{tail_pos, pd[l], po[l], 1'b0});
                tail_pos = (tail_pos + 1) % SPAN;
            end
        end
        g_dn = 0; g_fv = 0; g_cv[0] = 0; g_cv[1] = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1: actual 1 expected 0 (run hung)");
        summary();
    end

    initial begin
        g_cv[0] = 0; g_cv[1] = 0; g_cpos[0] = 0; g_cpos[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R8: state straight after reset.
        step();
        step();
        // R2: fill the list with groups of four, nothing completes.
        ph = "R2";
        while (q.size() < D) begin g_dn = 4; step(); end
        // R3: requests against a full list, and an oversize request.
        ph = "R3";
        g_dn = 1; step();
        g_dn = 4; step();
        // R4/R5: younger entries complete first; nothing may retire.
        ph = "R4";
        g_cv[0] = 1; g_cpos[0] = q[2].pos; g_cv[1] = 1; g_cpos[1] = q[3].pos; step();
        step();
        ph = "R5";
        g_cv[0] = 1; g_cpos[0] = q[0].pos; step();
        step();
        g_cv[0] = 1; g_cpos[0] = q[0].pos; step();
        step();
        for (int i = 0; i < 8; i++) begin
            g_cv[0] = 1; g_cpos[0] = q[4 + 2*i].pos;
            g_cv[1] = 1; g_cpos[1] = q[5 + 2*i].pos; step();
        end
        step(); step(); step(); step(); step();
        // R3: oversize group with room, then a fitting group.
        ph = "R3";
        g_dn = 5; step();
        g_dn = 3; step();
        // R4: completion to the tail tag (not live) must be ignored.
        ph = "R4";
        g_cv[0] = 1; g_cpos[0] = tail_pos; step();
        g_dn = 1; step();
        step(); step();
        // R6: flush mid-list with a dispatch and a completion to a flushed entry.
        ph = "R6";
        g_cv[0] = 1; g_cpos[0] = q[0].pos; g_cv[1] = 1; g_cpos[1] = q[8].pos;
        g_fv = 1; g_fpos = q[5].pos; g_dn = 2; step();
        step();
        g_dn = 4; step();
        g_fv = 1; g_fpos = q[0].pos; step();
        step();
        // R7: long random run that wraps the pointers many times.
        ph = "R7";
        for (int i = 0; i < 3000; i++) begin
            g_dn = int'($urandom_range(5));
            for (int c = 0; c < 2; c++) begin
                if (q.size() > 0 && $urandom_range(9) < 8) begin
                    g_cv[c] = 1; g_cpos[c] = q[$urandom_range(q.size() - 1)].pos;
                end else begin
                    g_cv[c] = int'($urandom_range(1)); g_cpos[c] = tail_pos;
                end
            end
            if (q.size() > 0 && $urandom_range(99) < 3) begin
                g_fv = 1; g_fpos = q[$urandom_range(q.size() - 1)].pos;
            end
            step();
        end
        summary();
    end

endmodule